// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and the cell array of a byte-wide flash memory. Every host write carries an address and a data byte. The controller treats the data byte as a command code, or as the second half of a two-write sequence. What a read returns depends on the current read mode. It can be a byte from the array, the status register, or one of two fixed identifier bytes selected by the address. Reads are combinational from the address, so the host sees the selected source on `rdata` without delay.

Byte program and block erase each take two writes: a setup code, then a second write that carries the target. Once a sequence is accepted, the controller raises a one-cycle request on the array side, along with the address, and the data byte for a program. It then runs a programmable busy timer in place of the internal write engine. An erase can be suspended and later resumed.

A separate active-low reset/power-down pin handles system reset. It aborts work in progress and blanks reads. When the pin is released, the controller starts in array-read mode with a known status pattern and ignores commands for a configurable wake-up period.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_n` is released, reads return `arr_rdata` (array mode), the status register holds 80h, and no array request is raised.
- R2: Each of these commands takes effect in a single write. FFh selects array reads. 70h selects status reads. 50h clears status bits 5 and 4 and leaves the read mode unchanged.
- R3: After a write of 90h, a read at address 0 returns 89h, a read at address 1 returns A2h, and a read at any other address returns 00h.
- R4: A command is taken only on the cycle where `wr_en` rises. Address and data are captured in that cycle, and holding `wr_en` high issues nothing further.
- R5: Byte program works with either setup code, 40h or 10h. The next write raises `arr_prog_req` for exactly one cycle, with `arr_addr` and `arr_wdata` equal to that write's address and data. The read mode switches to status, and status bit 7 (ready) reads 0 for exactly PROG_CYCLES cycles.
- R6: A write of 20h followed by D0h raises `arr_erase_req` for one cycle. `arr_addr` holds the written address with its low BLK_W bits forced to zero. Status bit 7 is 0 while the erase timer runs.
- R7: If an erase setup is followed by any byte other than D0h, the controller sets status bits 5 and 4, selects status reads, and raises no erase request.
- R8: During an erase, B0h freezes the timer and the status reads C0h (bit 7 ready, bit 6 suspended) until D0h resumes. After the resume, the erase completes in the cycles it had left.
- R9: A reserved command code changes neither the read mode nor the status.
- R10: While `pwr_rst_n` is low, `rdata` is 00h. In the first low cycle, if a program or erase is running, `arr_abort` is 1 and the operation is cancelled.
- R11: When `pwr_rst_n` is released, reads are in array mode, and the status register holds 80h with its error and suspend bits cleared.
- R12: For WAKE_CYCLES cycles after `pwr_rst_n` goes high, command writes are ignored. No array request can be raised while the pin is low.
- R13: While a program or erase is running, any command other than 70h, or B0h during an erase, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_rst_n | input | 1 | Reset/power-down pin, active low, sampled synchronously |
| wr_en | input | 1 | Host write strobe; a command is taken on its rising edge |
| addr | input | ADDR_W | Host address for reads and writes |
| wdata | input | 8 | Host write data / command code |
| rdata | output | 8 | Host read data (array, status or identifier) |
| arr_rdata | input | 8 | Byte read from the array at `addr` |
| arr_prog_req | output | 1 | One-cycle byte program request |
| arr_erase_req | output | 1 | One-cycle block erase request |
| arr_abort | output | 1 | Abort of the running operation |
| arr_addr | output | ADDR_W | Program address or block-aligned erase address |
| arr_wdata | output | 8 | Byte to be programmed |

## Verification
Most internal faults show up at the host read port. A wrong read-mode or status register appears on `rdata` at the sample point right after the edge that accepted the command. A wrong busy timer length appears as a ready bit that clears one cycle too early or too late, so the ready transition is counted cycle by cycle. A sequence state that is not cleared appears one write later, as a missing or stray array request pulse. A wake-up counter that is off by one shows only on a write placed inside the lockout window, so that window is probed on the first cycles after the pin is released.

// File: rtl/fcc_pkg.sv
// Package: shared command codes, identifier bytes and state encodings
// for the flash command interface controller.
package fcc_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_SUSP  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE        = 2'd0,
        SEQ_ERASE_SETUP = 2'd1,
        SEQ_PROG_SETUP  = 2'd2
    } seq_e;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_IDENT        = 8'h90;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;
    localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT     = 8'h10;

    localparam logic [7:0] ID_MAKER  = 8'h89;
    localparam logic [7:0] ID_DEVICE = 8'hA2;

endpackage

// File: rtl/fcc_wr_edge.sv
// Module: fcc_wr_edge
// Turns the host write strobe into a one-cycle write event on its rising
// edge. Assumes the strobe is synchronous to clk. The event is masked
// while the wake-up guard reports a lockout.
module fcc_wr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic lock,
    output logic wr_evt
);
    logic strobe_q;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // A write counts only on a low-to-high transition outside the lockout.
    assign wr_evt = strobe & ~strobe_q & ~lock;
endmodule

// File: rtl/fcc_wake_guard.sv
// Module: fcc_wake_guard
// Holds off command writes while the reset/power-down pin is low and for
// WAKE_CYCLES cycles after it returns high. Assumes the pin is already
// synchronous to clk.
module fcc_wake_guard #(
    parameter int WAKE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic locked
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);

    logic [CW-1:0] wake_cnt;

    // Reload while the pin is low, count down once it is released.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wake_cnt <= '0;
        else if (!pin_n)            wake_cnt <= CW'(WAKE_CYCLES);
        else if (wake_cnt != '0)    wake_cnt <= wake_cnt - 1'b1;
    end

    // Writes are blocked while the pin is low or the count has not drained.
    assign locked = ~pin_n | (wake_cnt != '0);
endmodule

// File: rtl/fcc_busy_timer.sv
// Module: fcc_busy_timer
// Stand-in for the internal write engine. It is loaded with a program or
// erase length, decrements while enabled and flags completion on its last
// count. Clearing it (abort) wins over every other action.
module fcc_busy_timer #(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load_prog,
    input  logic load_erase,
    input  logic run,
    output logic done
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Load, count down while running, or clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)             cnt <= '0;
        else if (load_prog)            cnt <= CW'(PROG_CYCLES);
        else if (load_erase)           cnt <= CW'(ERASE_CYCLES);
        else if (run && cnt != '0)     cnt <= cnt - 1'b1;
    end

    // Completion is the edge on which the final count is consumed.
    assign done = run && (cnt == CW'(1));
endmodule

// File: rtl/fcc_cmd_seq.sv
// Module: fcc_cmd_seq
// Command sequencer. It decodes single-write commands, tracks the
// two-write program and erase sequences, keeps the operation state, the
// read mode and the error flags, and registers the array-side request
// pulses with their address and data. Assumes wr_evt is already edge
// qualified and masked during lockout.
module fcc_cmd_seq
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              timer_done,
    output rd_mode_e          rd_mode,
    output op_e               op,
    output logic              err_erase,
    output logic              err_prog,
    output logic              start_prog,
    output logic              start_erase,
    output logic              prog_req,
    output logic              erase_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    seq_e seq;
    logic is_idle;
    logic is_busy;
    logic is_setup;

    assign is_idle  = (op == OP_NONE);
    assign is_busy  = (op == OP_PROG) || (op == OP_ERASE);
    assign is_setup = (wdata == CMD_PROG_SETUP) || (wdata == CMD_PROG_ALT);

    // Combinational start strobes so the timer loads on the same edge.
    always_comb begin
        start_prog  = wr_evt && (seq == SEQ_PROG_SETUP);
        start_erase = wr_evt && (seq == SEQ_ERASE_SETUP) && (wdata == CMD_CONFIRM);
    end

    // Main command state: sequence, operation, read mode, flags, requests.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_n) begin
            seq       <= SEQ_IDLE;
            op        <= OP_NONE;
            rd_mode   <= RM_ARRAY;
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            arr_addr  <= '0;
            arr_wdata <= '0;
        end else begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            if (timer_done) op <= OP_NONE;
            if (wr_evt) begin
                case (seq)
                    SEQ_PROG_SETUP: begin
                        arr_addr  <= addr;
                        arr_wdata <= wdata;
                        prog_req  <= 1'b1;
                        op        <= OP_PROG;
                        rd_mode   <= RM_STATUS;
                        seq       <= SEQ_IDLE;
                    end
                    SEQ_ERASE_SETUP: begin
                        rd_mode <= RM_STATUS;
                        seq     <= SEQ_IDLE;
                        if (wdata == CMD_CONFIRM) begin
                            arr_addr  <= {addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
                            erase_req <= 1'b1;
                            op        <= OP_ERASE;
                        end else begin
                            err_erase <= 1'b1;
                            err_prog  <= 1'b1;
                        end
                    end
                    default: begin
                        if (is_busy) begin
                            if (wdata == CMD_READ_STATUS)
                                rd_mode <= RM_STATUS;
                            else if (wdata == CMD_SUSPEND && op == OP_ERASE && !timer_done)
                                op <= OP_SUSP;
                        end else begin
                            case (wdata)
                                CMD_READ_ARRAY:   rd_mode <= RM_ARRAY;
                                CMD_READ_STATUS:  rd_mode <= RM_STATUS;
                                CMD_IDENT:        rd_mode <= RM_IDENT;
                                CMD_CLEAR_STATUS: begin
                                    err_erase <= 1'b0;
                                    err_prog  <= 1'b0;
                                end
                                CMD_CONFIRM: begin
                                    if (op == OP_SUSP) op <= OP_ERASE;
                                end
                                CMD_ERASE_SETUP: begin
                                    if (is_idle) begin
                                        seq     <= SEQ_ERASE_SETUP;
                                        rd_mode <= RM_STATUS;
                                    end
                                end
                                default: begin
                                    if (is_idle && is_setup) begin
                                        seq     <= SEQ_PROG_SETUP;
                                        rd_mode <= RM_STATUS;
                                    end
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: flash_cmd_ctrl (top)
// Flash command interface controller. It joins the write-edge detector,
// the wake-up guard, the command sequencer and the busy timer, assembles
// the status byte and selects the read data. Assumes all inputs are
// synchronous to clk; array read data arrives combinationally for addr.
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int BLK_W        = 16,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 24,
    parameter int WAKE_CYCLES  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        arr_rdata,
    output logic              arr_prog_req,
    output logic              arr_erase_req,
    output logic              arr_abort,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    logic     locked;
    logic     wr_evt;
    logic     timer_done;
    logic     start_prog;
    logic     start_erase;
    logic     err_erase;
    logic     err_prog;
    logic     running;
    rd_mode_e rd_mode;
    op_e      op;
    logic [7:0] status;

    fcc_wake_guard #(.WAKE_CYCLES(WAKE_CYCLES)) wake_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (pwr_rst_n),
        .locked (locked)
    );

    fcc_wr_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (wr_en),
        .lock   (locked),
        .wr_evt (wr_evt)
    );

    fcc_cmd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n       (pwr_rst_n),
        .wr_evt      (wr_evt),
        .addr        (addr),
        .wdata       (wdata),
        .timer_done  (timer_done),
        .rd_mode     (rd_mode),
        .op          (op),
        .err_erase   (err_erase),
        .err_prog    (err_prog),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .prog_req    (arr_prog_req),
        .erase_req   (arr_erase_req),
        .arr_addr    (arr_addr),
        .arr_wdata   (arr_wdata)
    );

    fcc_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (~pwr_rst_n),
        .load_prog  (start_prog),
        .load_erase (start_erase),
        .run        (running),
        .done       (timer_done)
    );

    assign running = (op == OP_PROG) || (op == OP_ERASE);

    // Status byte: ready, suspended, erase error, program error, zeros.
    always_comb begin
        status = {~running, (op == OP_SUSP), err_erase, err_prog, 4'b0000};
    end

    // Abort is raised while the pin is low and an operation still runs.
    assign arr_abort = ~pwr_rst_n & running;

    // Read data selection by read mode; blanked while the pin is low.
    always_comb begin
        rdata = 8'h00;
        if (pwr_rst_n) begin
            case (rd_mode)
                RM_STATUS: rdata = status;
                RM_IDENT: begin
                    if (addr == ADDR_W'(0))      rdata = ID_MAKER;
                    else if (addr == ADDR_W'(1)) rdata = ID_DEVICE;
                end
                default:   rdata = arr_rdata;
            endcase
        end
    end
endmodule

// File: rtl/fcc_checker.sv
// Module: fcc_checker
// Port-level properties of the flash command controller, bound to every
// instance of the top module.
module fcc_checker #(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_rst_n,
    input logic [7:0]        rdata,
    input logic [7:0]        arr_rdata,
    input logic              arr_prog_req,
    input logic              arr_erase_req,
    input logic              arr_abort,
    input logic [ADDR_W-1:0] arr_addr
);
    // R5: a program request lasts one cycle.
    p_prog_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_prog_req |=> !arr_prog_req);

    // R6: an erase request lasts one cycle.
    p_erase_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_req |=> !arr_erase_req);

    // R6: the erase address is block aligned.
    p_blk_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_req |-> (arr_addr[BLK_W-1:0] == '0));

    // R13: program and erase requests never coincide.
    p_one_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_prog_req, arr_erase_req}));

    // R10: reads are blanked while the pin is low.
    p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_rst_n |-> (rdata == 8'h00));

    // R10: abort appears only with the pin low.
    p_abort_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_abort |-> !pwr_rst_n);

    // R11: release from the pin returns reads to array mode.
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_rst_n) |-> (rdata == arr_rdata));

    // R12: no request follows a cycle with the pin low.
    p_no_req_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_rst_n |=> (!arr_prog_req && !arr_erase_req));
endmodule

bind flash_cmd_ctrl fcc_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_rst_n     (pwr_rst_n),
    .rdata         (rdata),
    .arr_rdata     (arr_rdata),
    .arr_prog_req  (arr_prog_req),
    .arr_erase_req (arr_erase_req),
    .arr_abort     (arr_abort),
    .arr_addr      (arr_addr)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
// Testbench for flash_cmd_ctrl: a vector table walked by one loop, then
// directed tests for the program, erase, pin and reset corner cases.
module flash_cmd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int BLK_W      = 16;
    localparam int PROG_C     = 8;
    localparam int ERASE_C    = 24;
    localparam int WAKE_C     = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              pwr_rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
    logic [7:0]        rdata;
    logic [7:0]        arr_rdata;
    logic              arr_prog_req;
    logic              arr_erase_req;
    logic              arr_abort;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Array model: contents derived from the address.
    assign arr_rdata = addr[7:0] ^ 8'h5A;

    flash_cmd_ctrl #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYCLES(PROG_C),
        .ERASE_CYCLES(ERASE_C), .WAKE_CYCLES(WAKE_C)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_rst_n(pwr_rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .arr_rdata(arr_rdata),
        .arr_prog_req(arr_prog_req), .arr_erase_req(arr_erase_req),
        .arr_abort(arr_abort), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] a;
        logic [7:0]        d;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 20'h00010, 8'h4A, 4'd1},   // R1 array read after reset
        '{1'b1, 20'h00000, 8'h70, 4'd2},   // R2 status mode
        '{1'b0, 20'h00000, 8'h80, 4'd2},
        '{1'b1, 20'h00000, 8'h90, 4'd3},   // R3 identifier mode
        '{1'b0, 20'h00000, 8'h89, 4'd3},
        '{1'b0, 20'h00001, 8'hA2, 4'd3},
        '{1'b0, 20'h00002, 8'h00, 4'd3},
        '{1'b1, 20'h00000, 8'h3C, 4'd9},   // R9 reserved code
        '{1'b0, 20'h00001, 8'hA2, 4'd9},
        '{1'b1, 20'h00000, 8'hFF, 4'd2},   // R2 array mode
        '{1'b0, 20'h00033, 8'h69, 4'd2},
        '{1'b1, 20'h10000, 8'h20, 4'd7},   // R7 bad confirm
        '{1'b1, 20'h10000, 8'h55, 4'd7},
        '{1'b0, 20'h00000, 8'hB0, 4'd7},
        '{1'b1, 20'h00000, 8'h50, 4'd2},   // R2 clear status
        '{1'b0, 20'h00000, 8'h80, 4'd2},
        '{1'b1, 20'h00000, 8'h77, 4'd9},   // R9 reserved code in status mode
        '{1'b0, 20'h00000, 8'h80, 4'd9}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; pwr_rst_n = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 no prog req", arr_prog_req, 0);
        chk("R1 no erase req", arr_erase_req, 0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                do_write(VECS[i].a, VECS[i].d);
            end else begin
                @(negedge clk);
                addr = VECS[i].a;
                #1;
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), rdata, VECS[i].d);
            end
        end

        // R5: program with setup 40h, exact busy length.
        do_write(20'h00000, 8'h40);
        do_write(20'h0ABCD, 8'h3C);
        #1;
        chk("R5 prog req", arr_prog_req, 1);
        chk("R5 prog addr", arr_addr, 20'h0ABCD);
        chk("R5 prog data", arr_wdata, 8'h3C);
        chk("R5 status busy", rdata, 8'h00);
        n = 1;
        @(negedge clk); #1;
        chk("R5 pulse one cycle", arr_prog_req, 0);
        while (rdata[7] == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk); #1;
        end
        chk("R5 busy cycles", n, PROG_C);
        chk("R5 ready status", rdata, 8'h80);

        // R5 alias 10h, with R13 commands ignored while busy.
        do_write(20'h00000, 8'h10);
        do_write(20'h00777, 8'hE1);
        #1;
        chk("R5 alt setup req", arr_prog_req, 1);
        chk("R5 alt setup data", arr_wdata, 8'hE1);
        do_write(20'h00000, 8'hFF);
        do_write(20'h30000, 8'h20);
        #1;
        chk("R13 FF ignored while busy", rdata, 8'h00);
        n = 0;
        while (rdata[7] == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk); #1;
        end
        chk("R13 status kept", rdata, 8'h80);
        do_write(20'h30000, 8'hD0);
        #1;
        chk("R13 setup ignored while busy", arr_erase_req, 0);

        // R6 erase, R8 suspend and resume.
        do_write(20'h2ABCD, 8'h20);
        do_write(20'h2ABCD, 8'hD0);
        #1;
        chk("R6 erase req", arr_erase_req, 1);
        chk("R6 block address", arr_addr, 20'h20000);
        chk("R6 status busy", rdata, 8'h00);
        do_write(20'h00000, 8'hB0);
        #1;
        chk("R8 suspended status", rdata, 8'hC0);
        repeat (10) @(negedge clk);
        #1;
        chk("R8 timer frozen", rdata, 8'hC0);
        do_write(20'h00000, 8'hD0);
        #1;
        chk("R8 resumed status", rdata, 8'h00);
        n = 0;
        while (rdata[7] == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk); #1;
        end
        chk("R8 remaining cycles", n, ERASE_C - 2);
        chk("R6 erase done status", rdata, 8'h80);

        // R4: only the rising edge of the strobe counts.
        @(negedge clk);
        addr = 20'h00000; wdata = 8'hFF; wr_en = 1'b1;
        @(negedge clk); wdata = 8'h70;
        @(negedge clk); wdata = 8'h90;
        @(negedge clk); wr_en = 1'b0;
        #1;
        chk("R4 held strobe one command", rdata, 8'h5A);

        // R10, R11, R12: pin abort, release and wake-up lockout.
        do_write(20'h00000, 8'h20);
        do_write(20'h00000, 8'hFF);
        do_write(20'h00000, 8'h40);
        do_write(20'h00055, 8'h11);
        @(negedge clk);
        pwr_rst_n = 1'b0;
        #1;
        chk("R10 abort raised", arr_abort, 1);
        chk("R10 reads blanked", rdata, 8'h00);
        @(negedge clk); #1;
        chk("R10 abort single cycle", arr_abort, 0);
        @(negedge clk);
        pwr_rst_n = 1'b1;
        addr = 20'h00044;
        #1;
        chk("R11 array mode on release", rdata, 8'h1E);
        do_write(20'h00000, 8'h70);
        #1;
        chk("R12 write locked out", rdata, 8'h5A);
        repeat (WAKE_C) @(negedge clk);
        do_write(20'h00000, 8'h70);
        #1;
        chk("R11 status after release", rdata, 8'h80);

        // R1: synchronous reset from a state with errors.
        do_write(20'h00000, 8'h20);
        do_write(20'h00000, 8'h11);
        #1;
        chk("R7 error status before reset", rdata, 8'hB0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 array mode after reset", rdata, 8'h5A);
        do_write(20'h00000, 8'h70);
        #1;
        chk("R1 status after reset", rdata, 8'h80);

        finish_run();
    end
endmodule